// File: doc/BRIEF.md
# In-Flight Packet Release Counter

This block keeps a count of in-flight packets for every bucket and for every notification ring. A dispatch port adds one packet to a bucket counter and to a ring counter. Software returns packets with a memory-mapped write. The write address selects the bucket, the ring, or both, and the write data gives how many packets to return. The block decodes the address and rejects writes aimed at any other address region. It then subtracts the count from the selected counters. Each entry also records the ring number and group of its latest dispatch, and a sticky flag that shows software once tried to return more packets than were outstanding.

A registered read port lets software inspect a bucket or a ring entry. The service-domain index in an accepted write is only captured and shown on an output. Permission checks and the load-balancing policy live elsewhere.

Top module: `inflight_release_ctr`

## Requirements
- R1: A write is accepted only when `wr_addr[2:0]` equals 4. A write with any other value there changes no counter and no flag.
- R2: A write with a wrong region value raises `rel_err` for exactly the one cycle after the write. At all other times `rel_err` is low.
- R3: An accepted write with `wr_addr[3]` set decrements the bucket counter selected by `wr_addr[25:13]`. Only the low `BKT_AW` bits of that index are used, so the index is taken modulo the bucket count.
- R4: An accepted write with `wr_addr[4]` set decrements the ring counter selected by `wr_addr[12:5]`. Only the low `RING_AW` bits of that index are used.
- R5: When both enable bits are set, one write decrements both counters. When neither is set, the write changes nothing.
- R6: The decrement is exactly `wr_data[15:0]`. Bits `wr_data[31:16]` are ignored.
- R7: A decrement larger than the current count leaves that counter at zero and sets the entry's underflow flag. The flag stays set until reset.
- R8: A dispatch adds one to bucket `disp_bucket` and to ring `disp_ring`. Both entries store `disp_ring` and `disp_group` as their tag. A counter at 65535 stays at 65535.
- R9: A dispatch and a release that hit the same counter in the same cycle are applied as one net update (count + 1 - release, floored at zero).
- R10: `rd_en` with `rd_ring_sel` (0 = bucket, 1 = ring) and `rd_idx` returns count, tag and underflow flag on `rd_vld` one cycle later. The values read are those before any update made in that same cycle.
- R11: `svc_dom_q` takes `wr_addr[30:26]` one cycle after each accepted write and holds its value otherwise.
- R12: After reset every counter, tag and flag is zero, and `rd_vld`, `rel_err` and `svc_dom_q` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Release write strobe |
| wr_addr | input | 32 | Release address: region, enables, ring, bucket, service domain |
| wr_data | input | 32 | Release data; low 16 bits are the count |
| disp_en | input | 1 | Dispatch strobe |
| disp_bucket | input | 13 | Bucket receiving the dispatched packet |
| disp_ring | input | 8 | Ring receiving the dispatched packet |
| disp_group | input | 5 | Group recorded with the dispatch |
| rd_en | input | 1 | Read strobe |
| rd_ring_sel | input | 1 | 0 reads a bucket, 1 reads a ring |
| rd_idx | input | 13 | Entry to read |
| rd_vld | output | 1 | Read result valid |
| rd_count | output | 16 | In-flight count of the entry read |
| rd_ring | output | 8 | Ring number stored in the entry |
| rd_group | output | 5 | Group stored in the entry |
| rd_uflow | output | 1 | Sticky underflow flag of the entry |
| rel_err | output | 1 | One-cycle pulse for a rejected write |
| svc_dom_q | output | 5 | Service domain of the last accepted write |

## Verification
The assertions check on every cycle the timing of the error pulse, the holding of the captured service domain, the one-cycle read latency and the stickiness of the underflow flag. They also check that a release without a dispatch never raises a counter. The exact values can only be seen in the bench's scenarios. These cover a decrement by the data field alone, saturation at both ends, the net result of a dispatch and a release on the same counter, index folding, and a read that returns the state from before its own cycle. A scoreboard model predicts each read.

// File: rtl/ifr_pkg.sv
package ifr_pkg;
  localparam int ADDR_W     = 32;
  localparam int DATA_W     = 32;
  localparam int CNT_W      = 16;
  localparam int BKT_FLD_W  = 13;
  localparam int RING_FLD_W = 8;
  localparam int GRP_W      = 5;
  localparam int SVC_W      = 5;
  localparam int TAG_W      = RING_FLD_W + GRP_W;

  localparam int REG_LSB  = 0;
  localparam int BEN_BIT  = 3;
  localparam int REN_BIT  = 4;
  localparam int RIDX_LSB = 5;
  localparam int BIDX_LSB = 13;
  localparam int SVC_LSB  = 26;

  localparam logic [2:0] REGION_RELEASE = 3'd4;
endpackage

// File: rtl/ifr_decode.sv
module ifr_decode
  import ifr_pkg::*;
#(
  parameter int BKT_AW  = 6,
  parameter int RING_AW = 4
) (
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [DATA_W-1:0]    wr_data,
  output logic                 accept,
  output logic                 reject,
  output logic                 bkt_dec,
  output logic [BKT_AW-1:0]    bkt_idx,
  output logic                 ring_dec,
  output logic [RING_AW-1:0]   ring_idx,
  output logic [CNT_W-1:0]     amount,
  output logic [SVC_W-1:0]     svc
);
  logic [2:0]            region;
  logic [BKT_FLD_W-1:0]  bkt_full;
  logic [RING_FLD_W-1:0] ring_full;
  logic                  unused_bits;

  assign region    = wr_addr[REG_LSB +: 3];
  assign bkt_full  = wr_addr[BIDX_LSB +: BKT_FLD_W];
  assign ring_full = wr_addr[RIDX_LSB +: RING_FLD_W];

  assign accept   = wr_en && (region == REGION_RELEASE);
  assign reject   = wr_en && (region != REGION_RELEASE);
  assign bkt_dec  = accept && wr_addr[BEN_BIT];
  assign ring_dec = accept && wr_addr[REN_BIT];
  assign bkt_idx  = bkt_full[BKT_AW-1:0];
  assign ring_idx = ring_full[RING_AW-1:0];
  assign amount   = wr_data[CNT_W-1:0];
  assign svc      = wr_addr[SVC_LSB +: SVC_W];

  assign unused_bits = ^{wr_addr[ADDR_W-1], bkt_full, ring_full, wr_data};
endmodule

// File: rtl/ifr_cnt_bank.sv
module ifr_cnt_bank #(
  parameter int AW = 6,
  parameter int CW = 16,
  parameter int TW = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc_en,
  input  logic [AW-1:0] inc_idx,
  input  logic [TW-1:0] inc_tag,
  input  logic          dec_en,
  input  logic [AW-1:0] dec_idx,
  input  logic [CW-1:0] dec_amt,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_idx,
  output logic          rd_vld,
  output logic [CW-1:0] rd_cnt,
  output logic [TW-1:0] rd_tag,
  output logic          rd_uf
);
  localparam int DEPTH = 1 << AW;

  logic [CW-1:0] cnt_mem [DEPTH];
  logic [TW-1:0] tag_mem [DEPTH];
  logic          uf_mem  [DEPTH];

  logic          same;
  logic [CW:0]   inc_res;
  logic [CW:0]   dec_res;

  // result is {underflow, new count}
  function automatic logic [CW:0] apply(input logic [CW-1:0] cur,
                                        input logic inc,
                                        input logic [CW-1:0] amt);
    logic [CW:0] sum;
    sum = {1'b0, cur} + {{CW{1'b0}}, inc};
    if ({1'b0, amt} > sum) return {1'b1, {CW{1'b0}}};
    sum = sum - {1'b0, amt};
    if (sum[CW]) return {1'b0, {CW{1'b1}}};
    return {1'b0, sum[CW-1:0]};
  endfunction

  always_comb begin
    same    = inc_en && dec_en && (inc_idx == dec_idx);
    inc_res = apply(cnt_mem[inc_idx], 1'b1, same ? dec_amt : '0);
    dec_res = apply(cnt_mem[dec_idx], 1'b0, dec_amt);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) begin
        cnt_mem[i] <= '0;
        tag_mem[i] <= '0;
        uf_mem[i]  <= 1'b0;
      end
      rd_vld <= 1'b0;
      rd_cnt <= '0;
      rd_tag <= '0;
      rd_uf  <= 1'b0;
    end else begin
      if (inc_en) begin
        cnt_mem[inc_idx] <= inc_res[CW-1:0];
        tag_mem[inc_idx] <= inc_tag;
        if (inc_res[CW]) uf_mem[inc_idx] <= 1'b1;
      end
      if (dec_en && !same) begin
        cnt_mem[dec_idx] <= dec_res[CW-1:0];
        if (dec_res[CW]) uf_mem[dec_idx] <= 1'b1;
      end
      rd_vld <= rd_en;
      if (rd_en) begin
        rd_cnt <= cnt_mem[rd_idx];
        rd_tag <= tag_mem[rd_idx];
        rd_uf  <= uf_mem[rd_idx];
      end
    end
  end

  // checker state: entry touched by a lone release in the previous cycle
  logic          chk_arm;
  logic [AW-1:0] chk_idx;
  logic [CW-1:0] chk_old;
  always_ff @(posedge clk) begin
    chk_arm <= !rst && dec_en && !inc_en;
    chk_idx <= dec_idx;
    chk_old <= cnt_mem[dec_idx];
  end

  // R3
  release_no_grow_chk: assert property (@(posedge clk) disable iff (rst)
    chk_arm |-> (cnt_mem[chk_idx] <= chk_old));

  // R10
  read_latency_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_vld);

  // R10
  read_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_vld);

  // R7
  uflow_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    uf_mem[0] |=> uf_mem[0]);
endmodule

// File: rtl/inflight_release_ctr.sv
module inflight_release_ctr
  import ifr_pkg::*;
#(
  parameter int BKT_AW  = 6,
  parameter int RING_AW = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [31:0]           wr_addr,
  input  logic [31:0]           wr_data,
  input  logic                  disp_en,
  input  logic [12:0]           disp_bucket,
  input  logic [7:0]            disp_ring,
  input  logic [4:0]            disp_group,
  input  logic                  rd_en,
  input  logic                  rd_ring_sel,
  input  logic [12:0]           rd_idx,
  output logic                  rd_vld,
  output logic [15:0]           rd_count,
  output logic [7:0]            rd_ring,
  output logic [4:0]            rd_group,
  output logic                  rd_uflow,
  output logic                  rel_err,
  output logic [4:0]            svc_dom_q
);
  logic               accept, reject, bkt_dec, ring_dec;
  logic [BKT_AW-1:0]  bkt_idx;
  logic [RING_AW-1:0] ring_idx;
  logic [CNT_W-1:0]   amount;
  logic [SVC_W-1:0]   svc;
  logic [TAG_W-1:0]   disp_tag;
  logic               sel_q;
  logic               b_vld, r_vld_unused;
  logic [CNT_W-1:0]   b_cnt, r_cnt;
  logic [TAG_W-1:0]   b_tag, r_tag;
  logic               b_uf, r_uf;
  logic               unused_idx;

  assign disp_tag   = {disp_ring, disp_group};
  assign unused_idx = ^{disp_bucket, disp_ring, rd_idx};

  ifr_decode #(.BKT_AW(BKT_AW), .RING_AW(RING_AW)) u_dec (
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .accept(accept), .reject(reject),
    .bkt_dec(bkt_dec), .bkt_idx(bkt_idx),
    .ring_dec(ring_dec), .ring_idx(ring_idx),
    .amount(amount), .svc(svc)
  );

  ifr_cnt_bank #(.AW(BKT_AW), .CW(CNT_W), .TW(TAG_W)) u_bkt (
    .clk(clk), .rst(rst),
    .inc_en(disp_en), .inc_idx(disp_bucket[BKT_AW-1:0]), .inc_tag(disp_tag),
    .dec_en(bkt_dec), .dec_idx(bkt_idx), .dec_amt(amount),
    .rd_en(rd_en && !rd_ring_sel), .rd_idx(rd_idx[BKT_AW-1:0]),
    .rd_vld(), .rd_cnt(b_cnt), .rd_tag(b_tag), .rd_uf(b_uf)
  );

  ifr_cnt_bank #(.AW(RING_AW), .CW(CNT_W), .TW(TAG_W)) u_ring (
    .clk(clk), .rst(rst),
    .inc_en(disp_en), .inc_idx(disp_ring[RING_AW-1:0]), .inc_tag(disp_tag),
    .dec_en(ring_dec), .dec_idx(ring_idx), .dec_amt(amount),
    .rd_en(rd_en && rd_ring_sel), .rd_idx(rd_idx[RING_AW-1:0]),
    .rd_vld(r_vld_unused), .rd_cnt(r_cnt), .rd_tag(r_tag), .rd_uf(r_uf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q     <= 1'b0;
      b_vld     <= 1'b0;
      rel_err   <= 1'b0;
      svc_dom_q <= '0;
    end else begin
      b_vld   <= rd_en;
      rel_err <= reject;
      if (rd_en) sel_q <= rd_ring_sel;
      if (accept) svc_dom_q <= svc;
    end
  end

  assign rd_vld   = b_vld;
  assign rd_count = sel_q ? r_cnt : b_cnt;
  assign {rd_ring, rd_group} = sel_q ? r_tag : b_tag;
  assign rd_uflow = sel_q ? r_uf : b_uf;

  // R2
  bad_region_err_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr[2:0] != 3'd4) |=> rel_err);

  // R2
  err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_addr[2:0] != 3'd4) |=> !rel_err);

  // R11
  svc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_addr[2:0] == 3'd4) |=> $stable(svc_dom_q));
endmodule

// File: tb/inflight_release_ctr_tb.sv
`timescale 1ns/1ps
module inflight_release_ctr_tb;
  localparam int BKT_AW  = 6;
  localparam int RING_AW = 4;
  localparam int NB = 1 << BKT_AW;
  localparam int NR = 1 << RING_AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 0, disp_en = 0, rd_en = 0, rd_ring_sel = 0;
  logic [31:0] wr_addr = '0, wr_data = '0;
  logic [12:0] disp_bucket = '0, rd_idx = '0;
  logic [7:0]  disp_ring = '0;
  logic [4:0]  disp_group = '0;
  logic        rd_vld, rd_uflow, rel_err;
  logic [15:0] rd_count;
  logic [7:0]  rd_ring;
  logic [4:0]  rd_group, svc_dom_q;

  always #2.5 clk = ~clk;

  inflight_release_ctr #(.BKT_AW(BKT_AW), .RING_AW(RING_AW)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .disp_en(disp_en), .disp_bucket(disp_bucket), .disp_ring(disp_ring),
    .disp_group(disp_group), .rd_en(rd_en), .rd_ring_sel(rd_ring_sel),
    .rd_idx(rd_idx), .rd_vld(rd_vld), .rd_count(rd_count), .rd_ring(rd_ring),
    .rd_group(rd_group), .rd_uflow(rd_uflow), .rel_err(rel_err),
    .svc_dom_q(svc_dom_q)
  );

  typedef struct {
    int    cnt;
    int    ring;
    int    grp;
    int    uf;
    string req;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  int mb_cnt [NB]; int mb_ring [NB]; int mb_grp [NB]; int mb_uf [NB];
  int mr_cnt [NR]; int mr_ring [NR]; int mr_grp [NR]; int mr_uf [NR];

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic logic [31:0] mk_addr(input int region, input bit ben, input bit ren,
                                          input int bidx, input int ridx, input int svc);
    logic [31:0] a;
    a = '0;
    a[2:0]   = region[2:0];
    a[3]     = ben;
    a[4]     = ren;
    a[12:5]  = ridx[7:0];
    a[25:13] = bidx[12:0];
    a[30:26] = svc[4:0];
    return a;
  endfunction

  function automatic int clampv(input int v);
    if (v < 0) return 0;
    if (v > 65535) return 65535;
    return v;
  endfunction

  // one cycle of stimulus; the model is updated as the requirements state
  task automatic step(input bit we, input logic [31:0] a, input logic [31:0] d,
                      input bit de, input int db, input int dr, input int dg,
                      input bit re, input bit rs, input int ri, input string req);
    int bi, ri2, rb, rr, amt, t;
    bit ok, bde, rde;
    exp_t e;
    wr_en = we; wr_addr = a; wr_data = d;
    disp_en = de; disp_bucket = db[12:0]; disp_ring = dr[7:0]; disp_group = dg[4:0];
    rd_en = re; rd_ring_sel = rs; rd_idx = ri[12:0];
    if (re) begin
      // R10: value from before this cycle's updates
      if (rs) begin
        t = ri % NR;
        e.cnt = mr_cnt[t]; e.ring = mr_ring[t]; e.grp = mr_grp[t]; e.uf = mr_uf[t];
      end else begin
        t = ri % NB;
        e.cnt = mb_cnt[t]; e.ring = mb_ring[t]; e.grp = mb_grp[t]; e.uf = mb_uf[t];
      end
      e.req = req;
      exp_q.push_back(e);
    end
    ok  = we && (a[2:0] == 3'd4);
    bde = ok && a[3];
    rde = ok && a[4];
    amt = int'(d[15:0]);
    rb  = int'(a[25:13]) % NB;
    rr  = int'(a[12:5]) % NR;
    bi  = db % NB;
    ri2 = dr % NR;
    if (de) begin
      t = mb_cnt[bi] + 1 - ((bde && rb == bi) ? amt : 0);
      if (t < 0) mb_uf[bi] = 1;
      mb_cnt[bi] = clampv(t); mb_ring[bi] = dr & 8'hFF; mb_grp[bi] = dg & 5'h1F;
      t = mr_cnt[ri2] + 1 - ((rde && rr == ri2) ? amt : 0);
      if (t < 0) mr_uf[ri2] = 1;
      mr_cnt[ri2] = clampv(t); mr_ring[ri2] = dr & 8'hFF; mr_grp[ri2] = dg & 5'h1F;
    end
    if (bde && !(de && rb == bi)) begin
      t = mb_cnt[rb] - amt;
      if (t < 0) mb_uf[rb] = 1;
      mb_cnt[rb] = clampv(t);
    end
    if (rde && !(de && rr == ri2)) begin
      t = mr_cnt[rr] - amt;
      if (t < 0) mr_uf[rr] = 1;
      mr_cnt[rr] = clampv(t);
    end
    @(negedge clk);
    wr_en = 0; disp_en = 0; rd_en = 0;
  endtask

  task automatic idle();
    step(0, '0, '0, 0, 0, 0, 0, 0, 0, 0, "");
  endtask

  task automatic rd(input bit rs, input int idx, input string req);
    step(0, '0, '0, 0, 0, 0, 0, 1, rs, idx, req);
  endtask

  task automatic rel(input logic [31:0] a, input logic [31:0] d);
    step(1, a, d, 0, 0, 0, 0, 0, 0, 0, "");
  endtask

  task automatic disp(input int b, input int r, input int g);
    step(0, '0, '0, 1, b, r, g, 0, 0, 0, "");
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && rd_vld) begin
      if (exp_q.size() == 0) begin
        check(0, "R10 unexpected rd_vld", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(int'(rd_count) == e.cnt, {e.req, " count"}, int'(rd_count), e.cnt);
        check(int'(rd_ring)  == e.ring, {e.req, " ring"}, int'(rd_ring), e.ring);
        check(int'(rd_group) == e.grp, {e.req, " group"}, int'(rd_group), e.grp);
        check(int'(rd_uflow) == e.uf, {e.req, " uflow"}, int'(rd_uflow), e.uf);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NB; i++) begin mb_cnt[i]=0; mb_ring[i]=0; mb_grp[i]=0; mb_uf[i]=0; end
    for (int i = 0; i < NR; i++) begin mr_cnt[i]=0; mr_ring[i]=0; mr_grp[i]=0; mr_uf[i]=0; end
    repeat (3) @(negedge clk);
    rst = 0;
    // R12 reset state
    check(rel_err == 0, "R12 rel_err", int'(rel_err), 0);
    check(rd_vld == 0, "R12 rd_vld", int'(rd_vld), 0);
    check(svc_dom_q == 0, "R12 svc_dom_q", int'(svc_dom_q), 0);
    rd(0, 3, "R12 bucket3");
    rd(1, 2, "R12 ring2");

    // R8 dispatch
    for (int i = 0; i < 5; i++) disp(3, 2, 7);
    rd(0, 3, "R8 bucket3");
    rd(1, 2, "R8 ring2");

    // R3 bucket only
    rel(mk_addr(4, 1, 0, 3, 2, 1), 32'd2);
    rd(0, 3, "R3 bucket3"); rd(1, 2, "R3 ring2 untouched");
    // R4 ring only
    rel(mk_addr(4, 0, 1, 3, 2, 1), 32'd1);
    rd(0, 3, "R4 bucket3 untouched"); rd(1, 2, "R4 ring2");
    // R5 both, R11 service domain
    rel(mk_addr(4, 1, 1, 3, 2, 9), 32'd1);
    check(svc_dom_q == 5'd9, "R11 svc_dom_q", int'(svc_dom_q), 9);
    rd(0, 3, "R5 bucket3 both"); rd(1, 2, "R5 ring2 both");
    // R5 neither
    rel(mk_addr(4, 0, 0, 3, 2, 11), 32'd1);
    rd(0, 3, "R5 bucket3 neither"); rd(1, 2, "R5 ring2 neither");
    // R1/R2 wrong region
    rel(mk_addr(5, 1, 1, 3, 2, 20), 32'd1);
    check(rel_err == 1, "R2 err pulse", int'(rel_err), 1);
    check(svc_dom_q == 5'd11, "R11 svc hold on reject", int'(svc_dom_q), 11);
    idle();
    check(rel_err == 0, "R2 err one cycle", int'(rel_err), 0);
    rd(0, 3, "R1 bucket3 after reject"); rd(1, 2, "R1 ring2 after reject");
    // R6 upper data ignored
    rel(mk_addr(4, 1, 0, 3, 0, 0), 32'hABCD_0001);
    rd(0, 3, "R6 bucket3");
    // R3 index folding: bucket 3 + NB aliases bucket 3
    disp(3, 2, 7); disp(3, 2, 7);
    rel(mk_addr(4, 1, 0, 3 + NB, 0, 0), 32'd1);
    rd(0, 3, "R3 folded index");
    // R7 underflow
    rel(mk_addr(4, 1, 1, 3, 2, 0), 32'd40);
    rd(0, 3, "R7 bucket3 underflow"); rd(1, 2, "R7 ring2 underflow");
    disp(3, 2, 6);
    rd(0, 3, "R7 bucket3 sticky");
    // R9 same-cycle net
    for (int i = 0; i < 4; i++) disp(3, 2, 6);
    step(1, mk_addr(4, 1, 1, 3, 2, 0), 32'd3, 1, 3, 2, 6, 0, 0, 0, "");
    rd(0, 3, "R9 bucket3 net"); rd(1, 2, "R9 ring2 net");
    // R9 dispatch and release to different counters in one cycle
    step(1, mk_addr(4, 1, 0, 3, 0, 0), 32'd1, 1, 8, 2, 1, 0, 0, 0, "");
    rd(0, 3, "R9 bucket3 other"); rd(0, 8, "R9 bucket8 other");
    // R10 read sees pre-update value
    step(0, '0, '0, 1, 8, 4, 2, 1, 0, 8, "R10 read before update");
    rd(0, 8, "R10 read after update");
    // R8 saturation at top
    for (int i = 0; i < 65536; i++) disp(10, 5, 3);
    rd(0, 10, "R8 bucket10 saturate"); rd(1, 5, "R8 ring5 saturate");
    idle(); idle();
    check(exp_q.size() == 0, "R10 all reads answered", exp_q.size(), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule